// File: doc/BRIEF.md
# Processor Hard-Reset and Soft-Init Sequencer

This block drives the two processor reset lines of a PC-style system controller: a hard reset that clears the processor entirely and a soft init that restarts it without losing cache or memory state. It runs on the PCI clock. The hard reset is held while power-good is low and for a parameterised minimum time after it rises. It is also held for that time after software requests a full reset through a two-bit control register, and such a request also emits a one-cycle pulse that returns the block's registers and the rest of the controller to their defaults.

A soft init is a pulse of fixed length. It is started by a kick through the control register with full-reset mode off, by a decoded shutdown special cycle, by a rising keyboard-controller reset request, or by a fast-reset port write whose bit 0 is 1. A strap selects whether both processor lines are active-high or active-low. All outputs come from registers, so every edge on them, including the release of the reset, follows a rising clock edge.

Top module: `cpu_rst_seq`

## Requirements
- R1: While `rst` is high the reset line is asserted, the init line is deasserted and `regs_default_o` is 0, in both strap polarities.
- R2: While `pwr_good` is low the reset line is asserted. It is released at the HARD_CYCLES-th consecutive rising edge at which `pwr_good` (and not `rst`) is sampled high. A low `pwr_good` restarts this count.
- R3: A control write with data bit 1 (kick) = 1 while the stored kick bit is 0, and data bit 0 (full reset) = 1, asserts the reset line from that edge for exactly HARD_CYCLES cycles.
- R4: That full-reset write pulses `regs_default_o` for exactly one cycle, and it clears both stored control bits to 0. As a result, a later write of kick = 1 counts as a fresh 0-to-1 kick.
- R5: A control write with kick going from stored 0 to 1 and full reset = 0 asserts init from that edge for exactly INIT_CYCLES cycles. A write with kick = 1 while the stored kick is already 1 starts nothing, and so does a write with kick = 0.
- R6: Init is also started by a one-cycle `shutdown_cyc`, by a 0-to-1 change of `kbc_rst_req`, and by `fast_wr` with `fast_wr_bit0` = 1. A held-high `kbc_rst_req` fires only once, and `fast_wr` with bit 0 = 0 has no effect.
- R7: An init request sampled while init is asserted, up to and including its release edge, neither extends nor restarts the pulse.
- R8: A full reset wins over init. An init request arriving with a full-reset write is dropped, an active init is cut at the edge the reset starts, and init requests sampled while the reset is held are dropped.
- R9: With `strap_act_low` = 0 both processor lines are high when asserted. With `strap_act_low` = 1 both are low when asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_good | input | 1 | Power-good, high when supplies are stable |
| rc_wr | input | 1 | Write strobe of the reset-control register |
| rc_wr_data | input | 2 | Write data: bit 0 full reset, bit 1 kick |
| shutdown_cyc | input | 1 | One-cycle pulse for a decoded shutdown special cycle |
| kbc_rst_req | input | 1 | Keyboard-controller reset request, active high |
| fast_wr | input | 1 | Write strobe of the fast-reset port |
| fast_wr_bit0 | input | 1 | Bit 0 of the fast-reset port write data |
| strap_act_low | input | 1 | Polarity strap: 1 selects active-low processor lines |
| cpu_rst_o | output | 1 | Processor hard-reset line |
| cpu_init_o | output | 1 | Processor soft-init line |
| regs_default_o | output | 1 | One-cycle pulse returning registers to their defaults |

## Verification
The two functions that can land in one cycle are the full-reset start and the init start. The bench provokes this by putting a full-reset control write and a shutdown pulse into the same cycle. It also issues a full-reset write partway through a running init, and raises init requests while the reset is being held. It judges each case by the exact number of cycles the reset line stays asserted and by the cycle in which init falls or stays low. It also sweeps a second init request over every cycle of an active pulse, including the release edge, and checks that the pulse length never changes.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  localparam int CTL_FULL_BIT = 0;
  localparam int CTL_KICK_BIT = 1;
  localparam int CTL_W        = 2;

  typedef struct packed {
    logic kick;
    logic full;
  } ctl_t;
endpackage

// File: rtl/min_width_timer.sv
module min_width_timer #(
  parameter int CYCLES  = 64,
  parameter bit RST_ACT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic start,
  input  logic trig,
  input  logic kill,
  output logic act_q,
  output logic act_d
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (kill) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (hold || start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (trig) begin
      act_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= RST_ACT;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && cnt_q != LAST && !kill) |=> act_q);

  // R3
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> ($past(cnt_q) == LAST || $past(kill)));
endmodule

// File: rtl/rst_ctl_reg.sv
module rst_ctl_reg
  import cpu_rst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic             hard_req,
  output logic             soft_req
);
  ctl_t ctl_q;
  logic kick_rise;

  assign kick_rise = wr_en && wr_data[CTL_KICK_BIT] && !ctl_q.kick;
  assign hard_req  = kick_rise && wr_data[CTL_FULL_BIT];
  assign soft_req  = kick_rise && !wr_data[CTL_FULL_BIT];

  always_ff @(posedge clk) begin
    if (rst || hard_req) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q.kick <= wr_data[CTL_KICK_BIT];
      ctl_q.full <= wr_data[CTL_FULL_BIT];
    end
  end
endmodule

// File: rtl/init_trig.sv
module init_trig (
  input  logic clk,
  input  logic rst,
  input  logic shutdown_cyc,
  input  logic kbc_rst_req,
  input  logic fast_wr,
  input  logic fast_wr_bit0,
  input  logic soft_req,
  output logic init_src
);
  logic kbc_q;

  always_ff @(posedge clk) begin
    if (rst) kbc_q <= 1'b0;
    else     kbc_q <= kbc_rst_req;
  end

  assign init_src = soft_req || shutdown_cyc ||
                    (kbc_rst_req && !kbc_q) ||
                    (fast_wr && fast_wr_bit0);
endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
  import cpu_rst_pkg::*;
#(
  parameter int HARD_CYCLES = 66000,
  parameter int INIT_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic             rc_wr,
  input  logic [CTL_W-1:0] rc_wr_data,
  input  logic             shutdown_cyc,
  input  logic             kbc_rst_req,
  input  logic             fast_wr,
  input  logic             fast_wr_bit0,
  input  logic             strap_act_low,
  output logic             cpu_rst_o,
  output logic             cpu_init_o,
  output logic             regs_default_o
);
  logic hard_req, soft_req, init_src;
  logic hard_q, hard_d, init_q, init_d;

  rst_ctl_reg u_ctl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rc_wr),
    .wr_data  (rc_wr_data),
    .hard_req (hard_req),
    .soft_req (soft_req)
  );

  init_trig u_trig (
    .clk          (clk),
    .rst          (rst),
    .shutdown_cyc (shutdown_cyc),
    .kbc_rst_req  (kbc_rst_req),
    .fast_wr      (fast_wr),
    .fast_wr_bit0 (fast_wr_bit0),
    .soft_req     (soft_req),
    .init_src     (init_src)
  );

  min_width_timer #(.CYCLES(HARD_CYCLES), .RST_ACT(1'b1)) u_hard (
    .clk   (clk),
    .rst   (rst),
    .hold  (!pwr_good),
    .start (hard_req),
    .trig  (1'b0),
    .kill  (1'b0),
    .act_q (hard_q),
    .act_d (hard_d)
  );

  // init is blocked and cut whenever the hard reset is held after this edge
  min_width_timer #(.CYCLES(INIT_CYCLES), .RST_ACT(1'b0)) u_init (
    .clk   (clk),
    .rst   (rst),
    .hold  (1'b0),
    .start (1'b0),
    .trig  (init_src),
    .kill  (hard_d),
    .act_q (init_q),
    .act_d (init_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rst_o      <= !strap_act_low;
      cpu_init_o     <= strap_act_low;
      regs_default_o <= 1'b0;
    end else begin
      cpu_rst_o      <= hard_d ^ strap_act_low;
      cpu_init_o     <= init_d ^ strap_act_low;
      regs_default_o <= hard_req;
    end
  end

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hard_q && init_q));

  // R4
  dflt_chk: assert property (@(posedge clk) disable iff (rst)
    regs_default_o |-> hard_q);

  // R2
  pg_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> hard_q);
endmodule

// File: tb/cpu_rst_seq_tb.sv
module cpu_rst_seq_tb;
  localparam int HARD = 20;
  localparam int INIT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, pwr_good = 1'b0, rc_wr = 1'b0;
  logic [1:0] rc_data = 2'b00;
  logic shutdown = 1'b0, kbc = 1'b0, fast_wr = 1'b0, fast_b0 = 1'b0, strap_lo = 1'b0;
  logic cpu_rst, cpu_init, dflt;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_rst_seq #(.HARD_CYCLES(HARD), .INIT_CYCLES(INIT)) u_dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .rc_wr(rc_wr), .rc_wr_data(rc_data),
    .shutdown_cyc(shutdown), .kbc_rst_req(kbc), .fast_wr(fast_wr), .fast_wr_bit0(fast_b0),
    .strap_act_low(strap_lo), .cpu_rst_o(cpu_rst), .cpu_init_o(cpu_init), .regs_default_o(dflt)
  );

  function automatic logic lv(logic a);
    return a ^ strap_lo;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic clr();
    rc_wr = 1'b0; shutdown = 1'b0; fast_wr = 1'b0; fast_b0 = 1'b0;
  endtask

  task automatic rcw(logic [1:0] d);
    rc_data = d; rc_wr = 1'b1;
  endtask

  // stimulus was driven before this call; sampled at the next edge
  task automatic init_window(string tag, int n);
    for (int j = 0; j <= n + 1; j++) begin
      nxt(); clr();
      chk(tag, cpu_init, lv(j < n));
    end
  endtask

  task automatic powerup(string tag);
    pwr_good = 1'b1; rst = 1'b0;
    for (int k = 0; k <= HARD; k++) begin
      nxt();
      chk(tag, cpu_rst, lv(k < HARD - 1));
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) nxt();
    chk("R1 reset line", cpu_rst, 1'b1);
    chk("R1 init line", cpu_init, 1'b0);
    chk("R1 defaults pulse", dflt, 1'b0);

    rst = 1'b0;
    repeat (4) begin nxt(); chk("R2 held while power bad", cpu_rst, lv(1'b1)); end
    powerup("R2 power-up release");
    pwr_good = 1'b0;
    repeat (2) begin nxt(); chk("R2 power drop", cpu_rst, lv(1'b1)); end
    powerup("R2 power-up recount");

    rcw(2'b10); init_window("R5 soft init", INIT);
    rcw(2'b10); init_window("R5 kick already set", 0);
    rcw(2'b00); nxt(); clr();
    rcw(2'b10); init_window("R5 soft init again", INIT);
    rcw(2'b00); nxt(); clr();
    rcw(2'b01); nxt(); clr();
    chk("R5 kick zero no reset", cpu_rst, lv(1'b0));
    chk("R5 kick zero no init", cpu_init, lv(1'b0));
    rcw(2'b00); nxt(); clr();

    shutdown = 1'b1; init_window("R6 shutdown", INIT);
    kbc = 1'b1; init_window("R6 keyboard edge", INIT);
    repeat (3) begin nxt(); chk("R6 keyboard held", cpu_init, lv(1'b0)); end
    kbc = 1'b0; nxt();
    fast_wr = 1'b1; fast_b0 = 1'b1; init_window("R6 fast port bit0 set", INIT);
    fast_wr = 1'b1; fast_b0 = 1'b0; init_window("R6 fast port bit0 clear", 0);

    for (int off = 0; off < INIT; off++) begin
      shutdown = 1'b1;
      for (int j = 0; j <= INIT + 1; j++) begin
        nxt(); clr();
        chk("R7 no extend", cpu_init, lv(j < INIT));
        if (j == off) begin fast_wr = 1'b1; fast_b0 = 1'b1; end
      end
    end

    rcw(2'b11);
    for (int j = 0; j <= HARD + 1; j++) begin
      nxt(); clr();
      chk("R3 hard reset width", cpu_rst, lv(j < HARD));
      chk("R4 defaults pulse", dflt, (j == 0));
    end
    rcw(2'b10); init_window("R4 control cleared", INIT);
    rcw(2'b00); nxt(); clr();

    rcw(2'b11); shutdown = 1'b1;
    for (int j = 0; j <= HARD + 1; j++) begin
      nxt(); clr();
      chk("R8 same-cycle reset", cpu_rst, lv(j < HARD));
      chk("R8 same-cycle init dropped", cpu_init, lv(1'b0));
      if (j == 5) begin fast_wr = 1'b1; fast_b0 = 1'b1; end
    end

    shutdown = 1'b1;
    for (int j = 0; j <= HARD + 4; j++) begin
      nxt(); clr();
      chk("R8 init cut", cpu_init, lv(j < 3));
      chk("R8 reset after cut", cpu_rst, lv(j >= 3 && j < 3 + HARD));
      if (j == 2) rcw(2'b11);
    end

    strap_lo = 1'b1; nxt();
    chk("R9 idle reset level", cpu_rst, 1'b1);
    chk("R9 idle init level", cpu_init, 1'b1);
    shutdown = 1'b1; init_window("R9 init active low", INIT);
    rcw(2'b11);
    for (int j = 0; j <= HARD + 1; j++) begin
      nxt(); clr();
      chk("R9 reset active low", cpu_rst, (j < HARD) ? 1'b0 : 1'b1);
    end
    rst = 1'b1; repeat (2) nxt();
    chk("R1 reset line low polarity", cpu_rst, 1'b0);
    chk("R1 init line low polarity", cpu_init, 1'b1);
    chk("R1 defaults pulse low polarity", dflt, 1'b0);
    powerup("R2 release after block reset");

    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finished");
      report();
    end
  end
endmodule